// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns host read and write requests into strobe sequences for an external bus on which the same lines carry the address and then the data. One clock period is one oscillator tick. A request carries an address, a byte-high enable, write data, an instruction-fetch flag and a two-bit wait-state count. The sequencer first drives the address and pulses the address latch enable. It then asserts a read or write strobe, releases or drives the data lines as the direction requires, and ends every cycle with one recovery tick that holds the qualifiers.

The bus width is chosen per cycle. The `bus_is16` input is sampled in the tick after the address strobe falls. In the narrow (8-bit) mode only the low byte lines carry data, and the upper address byte stays on `addr_hi` until the cycle ends. Read data is captured when the read strobe rises and is returned with a single-tick `done` pulse. A new request may be presented during that `done` tick, in which case the next cycle starts back to back.

States: `ST_IDLE` (nothing pending), `ST_ALE` (latch enable high, address on bus), `ST_ALOW` (latch enable low, address held, width sampled), `ST_STRB` (read or write strobe low for 1+2n ticks), `ST_HOLD` (strobe high, qualifiers held, `done` high). Transitions: IDLE→ALE on accept, ALE→ALOW and ALOW→STRB always, STRB→STRB while wait ticks remain, STRB→HOLD when they run out, HOLD→ALE on accept, HOLD→IDLE otherwise.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset and while idle: `ale`=0, `rd_n`=1, `wr_n`=1, `bhe_n`=1, `inst`=0, `bus_oe`=0, `addr_hi`=0, `busy`=0, `done`=0.
- R2: A cycle starts with `ale`=1 for exactly one tick. `bus_oe`=1 and `bus_out` equals the request address during that tick and the next one, and `addr_hi` equals the address upper byte during both ticks.
- R3: The read strobe (`rd_n`=0, for reads) or the write strobe (`wr_n`=0, for writes) goes low 2 ticks after `ale` rises and stays low for 1+2n ticks, where n is the wait-state count.
- R4: The tick after the strobe rises has `done`=1 and `busy`=0. `busy`=1 in every other tick of the cycle. A request (`req_valid`=1) is accepted only at a clock edge where `busy`=0. With a request held ready, `ale` rises every 4+2n ticks.
- R5: During a read, `bus_oe`=0 from the strobe's first low tick through the recovery tick. In the `done` tick, `rd_data` holds the value `bus_in` had in the last strobe-low tick.
- R6: During a write, `bus_oe`=1 and `bus_out` carries the write data from the strobe's first low tick through the recovery tick. In 8-bit mode `bus_out[15:8]`=0 and only bits 7:0 carry data.
- R7: `bus_is16` (1 = 16-bit, 0 = 8-bit) is taken only in the tick after `ale` falls. Its value in any other tick has no effect. In 8-bit mode `rd_data[15:8]`=0.
- R8: `bhe_n` equals the inverse of the request's byte-high enable, and `inst` equals its fetch flag, from the `ale` tick through the recovery tick.
- R9: From the strobe's first tick through the recovery tick, `addr_hi` keeps the address upper byte in 8-bit mode and is 0 in 16-bit mode.
- R10: `wait_states` and the request fields are taken only at the accepting edge. Their values at other times have no effect on the cycle.
- R11: `rd_n` and `wr_n` are never low in the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_bhe | input | 1 | Byte-high enable for this request |
| req_wdata | input | 16 | Write data |
| req_inst | input | 1 | Instruction-fetch flag |
| wait_states | input | 2 | Wait-state count n |
| bus_is16 | input | 1 | Width select, 1 = 16-bit |
| bus_in | input | 16 | Data read from the shared lines |
| busy | output | 1 | Cycle in progress, new request held off |
| done | output | 1 | One-tick cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | Byte-high enable, active low |
| inst | output | 1 | Instruction-fetch qualifier |
| addr_hi | output | 8 | Upper address byte |
| bus_out | output | 16 | Value driven on the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |

## Verification
The hardest case to reach is a new request that arrives while a cycle is still in progress and lands exactly on the recovery tick. That recovery tick must show the old cycle's qualifiers and write-data hold, while the new address strobe begins in the very next tick. The stimulus reaches it by raising `req_valid` mid-strobe and holding it through the busy ticks, and by presenting requests exactly in the `done` tick. Throughout, `wait_states` and `bus_is16` carry misleading values everywhere except at their sampling points.

// File: rtl/mux_bus_seq_pkg.sv
package mux_bus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_ALOW,
        ST_STRB,
        ST_HOLD
    } seq_state_t;

endpackage

// File: rtl/mux_bus_seq_wait.sv
module mux_bus_seq_wait #(
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [WSW-1:0] ws,
    input  logic           step,
    output logic           at_zero
);
    localparam int CW = WSW + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= {ws, 1'b0};
        end else if (step && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mux_bus_seq_pkg::*;
#(
    parameter int BW  = 16,
    parameter int WSW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BW-1:0]     req_addr,
    input  logic              req_bhe,
    input  logic [BW-1:0]     req_wdata,
    input  logic              req_inst,
    input  logic [WSW-1:0]    wait_states,
    input  logic              bus_is16,
    input  logic [BW-1:0]     bus_in,
    output logic              busy,
    output logic              done,
    output logic [BW-1:0]     rd_data,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bhe_n,
    output logic              inst,
    output logic [BW/2-1:0]   addr_hi,
    output logic [BW-1:0]     bus_out,
    output logic              bus_oe
);
    localparam int HB = BW / 2;

    seq_state_t       state, nxt;
    logic             accept;
    logic             wait_zero;
    logic             r_write, r_bhe, r_inst, r_wide;
    logic [BW-1:0]    r_addr, r_wdata;
    logic [WSW-1:0]   r_ws;
    logic [BW-1:0]    wdata_lane;

    assign accept = req_valid && (state == ST_IDLE || state == ST_HOLD);

    mux_bus_seq_wait #(.WSW(WSW)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == ST_ALOW),
        .ws      (r_ws),
        .step    (state == ST_STRB),
        .at_zero (wait_zero)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = accept ? ST_ALE : ST_IDLE;
            ST_ALE:  nxt = ST_ALOW;
            ST_ALOW: nxt = ST_STRB;
            ST_STRB: nxt = wait_zero ? ST_HOLD : ST_STRB;
            ST_HOLD: nxt = accept ? ST_ALE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and cycle registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            r_write <= 1'b0;
            r_bhe   <= 1'b0;
            r_inst  <= 1'b0;
            r_wide  <= 1'b1;
            r_addr  <= '0;
            r_wdata <= '0;
            r_ws    <= '0;
            rd_data <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                r_write <= req_write;
                r_bhe   <= req_bhe;
                r_inst  <= req_inst;
                r_addr  <= req_addr;
                r_wdata <= req_wdata;
                r_ws    <= wait_states;
            end
            if (state == ST_ALOW) begin
                r_wide <= bus_is16;
            end
            if (state == ST_STRB && wait_zero && !r_write) begin
                rd_data <= r_wide ? bus_in : {{HB{1'b0}}, bus_in[HB-1:0]};
            end
        end
    end

    assign wdata_lane = r_wide ? r_wdata : {{HB{1'b0}}, r_wdata[HB-1:0]};

    // output decode
    always_comb begin
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        bhe_n   = 1'b1;
        inst    = 1'b0;
        addr_hi = '0;
        bus_out = '0;
        bus_oe  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ALE, ST_ALOW: begin
                ale     = (state == ST_ALE);
                bhe_n   = ~r_bhe;
                inst    = r_inst;
                addr_hi = r_addr[BW-1:HB];
                bus_out = r_addr;
                bus_oe  = 1'b1;
                busy    = 1'b1;
            end
            ST_STRB, ST_HOLD: begin
                rd_n    = !(state == ST_STRB && !r_write);
                wr_n    = !(state == ST_STRB &&  r_write);
                bhe_n   = ~r_bhe;
                inst    = r_inst;
                addr_hi = r_wide ? '0 : r_addr[BW-1:HB];
                bus_out = r_write ? wdata_lane : '0;
                bus_oe  = r_write;
                busy    = (state == ST_STRB);
                done    = (state == ST_HOLD);
            end
            default: begin
            end
        endcase
    end

    // R5: never drive the shared lines while the read strobe is low
    a_r5_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    // R11: strobes mutually exclusive
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2: latch enable lasts a single tick
    a_r2_ale_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3: strobe falls two ticks after the latch enable rises
    a_r3_strobe_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> ##1 (!rd_n || !wr_n));

    // R4: done is a single tick and never overlaps busy
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && rd_n && wr_n));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/mux_bus_seq_tb.sv
`timescale 1ns/1ps
module mux_bus_seq_tb;

    localparam int NT = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_bhe, req_inst, bus_is16;
    logic [15:0] req_addr, req_wdata, bus_in;
    logic [1:0]  wait_states;
    logic        busy, done, ale, rd_n, wr_n, bhe_n, inst, bus_oe;
    logic [15:0] rd_data, bus_out;
    logic [7:0]  addr_hi;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mux_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bhe(req_bhe), .req_wdata(req_wdata),
        .req_inst(req_inst), .wait_states(wait_states), .bus_is16(bus_is16),
        .bus_in(bus_in), .busy(busy), .done(done), .rd_data(rd_data),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .inst(inst),
        .addr_hi(addr_hi), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    // memory stub: latches the address at the latch-enable fall
    logic [15:0] mem_addr = 16'h0;
    always @(negedge ale) mem_addr = bus_out;
    assign bus_in = !rd_n ? (mem_addr ^ 16'h5A3C) : 16'h0000;

    // transaction script
    bit          t_wr  [NT] = '{0, 1, 0, 1, 0, 1, 0, 1};
    logic [15:0] t_ad  [NT] = '{16'h1234, 16'h2468, 16'h8001, 16'hC0DE,
                                16'h7F10, 16'h0A0B, 16'hFFEE, 16'h3141};
    logic [15:0] t_wd  [NT] = '{16'h0, 16'hBEEF, 16'h0, 16'h1357,
                                16'h0, 16'hA5A5, 16'h0, 16'h9876};
    bit          t_bhe [NT] = '{1, 0, 1, 0, 1, 1, 0, 1};
    bit          t_in  [NT] = '{1, 0, 0, 1, 0, 0, 1, 0};
    int          t_ws  [NT] = '{0, 0, 2, 3, 1, 1, 3, 0};
    bit          t_16  [NT] = '{1, 1, 0, 0, 1, 1, 0, 0};
    int          t_gap [NT] = '{2, 0, 0, 3, -1, -1, 0, 1};

    // reference model state
    bit active = 0;
    int tt = 0;
    int cur = 0;
    int idx = 0;
    int idlecnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int last_of(input int k);
        return 3 + 2 * t_ws[k];
    endfunction

    task automatic check_idle();
        chk("R1 ale", ale, 0);
        chk("R1 rd_n", rd_n, 1);
        chk("R1 wr_n", wr_n, 1);
        chk("R1 bhe_n", bhe_n, 1);
        chk("R1 inst", inst, 0);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 addr_hi", addr_hi, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic check_tick();
        int n;
        int lst;
        bit stb;
        logic [15:0] rexp;
        if (!active) begin
            check_idle();
        end else begin
            n   = t_ws[cur];
            lst = last_of(cur);
            stb = (tt >= 2) && (tt <= 2 + 2 * n);
            chk("R2 ale", ale, tt == 0);
            chk("R3 R10 rd_n", rd_n, !(stb && !t_wr[cur]));
            chk("R3 R10 wr_n", wr_n, !(stb && t_wr[cur]));
            chk("R11 one strobe", rd_n | wr_n, 1);
            chk("R5 R6 bus_oe", bus_oe, (tt <= 1) || t_wr[cur]);
            if (tt <= 1) begin
                chk("R2 address on bus", bus_out, t_ad[cur]);
                chk("R2 addr_hi", addr_hi, t_ad[cur][15:8]);
            end else begin
                chk("R9 addr_hi", addr_hi, t_16[cur] ? 8'h00 : t_ad[cur][15:8]);
                if (t_wr[cur])
                    chk("R6 R7 write data", bus_out,
                        t_16[cur] ? t_wd[cur] : {8'h00, t_wd[cur][7:0]});
            end
            chk("R8 bhe_n", bhe_n, !t_bhe[cur]);
            chk("R8 inst", inst, t_in[cur]);
            chk("R4 busy", busy, tt != lst);
            chk("R4 done", done, tt == lst);
            if (tt == lst && !t_wr[cur]) begin
                rexp = t_ad[cur] ^ 16'h5A3C;
                if (!t_16[cur]) rexp[15:8] = 8'h00;
                chk("R5 R7 rd_data", rd_data, rexp);
            end
        end
    endtask

    initial begin
        int ticks;
        bit present;
        rst_n = 0;
        req_valid = 0; req_write = 0; req_addr = 0; req_bhe = 0;
        req_wdata = 0; req_inst = 0; wait_states = 0; bus_is16 = 1;
        repeat (3) @(negedge clk);
        check_idle();  // R1 during reset
        rst_n = 1;
        ticks = 0;
        while ((idx < NT || active) && ticks < 4000) begin
            check_tick();
            // width select valid only in the tick after ale falls
            bus_is16 = (active && tt == 1) ? t_16[cur] : !t_16[cur];
            present = 0;
            if (idx < NT) begin
                present = (!active && idlecnt >= (t_gap[idx] < 0 ? 0 : t_gap[idx]))
                       || (active && t_gap[idx] == 0 && tt == last_of(cur))
                       || (active && t_gap[idx] < 0 && tt >= 1);
            end
            req_valid = present;
            if (present) begin
                req_write = t_wr[idx]; req_addr = t_ad[idx]; req_wdata = t_wd[idx];
                req_bhe = t_bhe[idx]; req_inst = t_in[idx];
                wait_states = 2'(t_ws[idx]);
            end else begin
                // R10: junk on fields outside acceptance
                req_write = ticks[0]; req_addr = 16'(ticks * 16'h1111);
                req_wdata = ~req_addr; req_bhe = ticks[1]; req_inst = ticks[2];
                wait_states = 2'(ticks);
            end
            @(posedge clk);
            if (req_valid && (!active || tt == last_of(cur))) begin
                cur = idx; idx++; tt = 0; active = 1; idlecnt = 0;
            end else if (active) begin
                if (tt == last_of(cur)) active = 0;
                else tt++;
            end else begin
                idlecnt++;
            end
            @(negedge clk);
            ticks++;
        end
        req_valid = 0;
        repeat (3) begin
            check_idle();
            @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule